// File: doc/BRIEF.md
# Precise External Interrupt Recognition Unit

This unit sits at the retire end of an in-order pipeline and decides when a level-sensitive external interrupt request is taken, so that the interrupt stays precise. The request only counts as pending while the external-enable bit of the machine state is set. While it is pending, the unit holds off dispatch of new instructions into the completion queue and lets the older queue entries retire one per cycle in program order. It then looks at the youngest remaining entry. A completed, fault-free entry of a class that updates machine state or touches memory may retire ahead of the interrupt. Any other youngest entry is discarded and becomes the resume point.

The unit sees the head of a completion queue of up to `DEPTH` entries together with the queue occupancy. On taking an interrupt it raises a one-cycle flush and gives the vector address, saves the resume PC and the prior enable bit, and clears the enable bit. A fault flagged on the head entry is taken in preference to the external interrupt. A return-from-interrupt strobe restores the enable bit from the saved copy.

Top module: `ext_irq_recog`

## Requirements
- R1: After reset `msr_ee`, `saved_ee`, `flush`, `disp_stall` and `take_cause` are 0 and `srr0_pc` is 0.
- R2: The request is pending only while `ext_irq` and `msr_ee` are both 1. `disp_stall` equals pending, and with `msr_ee` 0 a raised request causes no flush.
- R3: While pending with `q_count` greater than 1, the head retires when `hd_done` is 1 and waits otherwise. No flush occurs.
- R4: While pending with `q_count` equal to 1, a head that is done, fault-free and of class code 1, 2, 3, 4 or 5 retires in the same cycle as the take. The saved resume PC is then `hd_pc + 4`.
- R5: While pending with `q_count` equal to 1, a head that is not done, or whose class code is 0, 6 or 7, is discarded (`retire` 0) and the interrupt is taken with resume PC `hd_pc`.
- R6: While pending with `q_count` equal to 0, the interrupt is taken with resume PC `nxt_pc`.
- R7: A head that is done with `hd_exc` 1 is never retired. It is taken with `take_cause` 2, resume PC `hd_pc` and target `VEC_BASE | hd_vec_off`, whatever the request is doing.
- R8: An external take shows `take_cause` 1 and target `VEC_BASE | 0x500`. The unit never redirects to offset 0x300 or 0x400 on its own.
- R9: Any take clears `msr_ee` on the next cycle and copies its prior value into `saved_ee`. The external flush lasts exactly one cycle.
- R10: `rfi_strobe` loads `msr_ee` from `saved_ee`. `ee_wr` loads it from `ee_wdata` and has lower priority than `rfi_strobe`. A take has priority over both.
- R11: With nothing pending and no head fault, the head retires exactly when `q_count` is non-zero and `hd_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq | input | 1 | Level-sensitive external interrupt request |
| nxt_pc | input | 32 | PC of the next instruction to dispatch |
| q_count | input | 3 | Number of valid completion queue entries |
| hd_done | input | 1 | Head entry has completed execution |
| hd_exc | input | 1 | Head entry raised its own exception |
| hd_cls | input | 3 | Head entry class code |
| hd_pc | input | 32 | Head entry PC |
| hd_vec_off | input | 12 | Vector offset of a head entry exception |
| rfi_strobe | input | 1 | Return-from-interrupt restore of the enable bit |
| ee_wr | input | 1 | Write strobe for the enable bit |
| ee_wdata | input | 1 | Value for the enable bit write |
| retire | output | 1 | Head entry retires this cycle |
| disp_stall | output | 1 | Hold off dispatch into the queue |
| flush | output | 1 | Discard queue contents and redirect fetch |
| take_cause | output | 2 | 0 none, 1 external, 2 head exception |
| redirect_pc | output | 32 | Vector address, valid with flush |
| srr0_pc | output | 32 | Saved resume PC |
| msr_ee | output | 1 | External-enable bit |
| saved_ee | output | 1 | Enable bit saved at the last take |

## Verification
The hardest case to reach is the single-entry decision. The request must be pending while exactly one entry remains, and that entry's class and completion state must vary with nothing else changing. The bench reaches it by setting the enable bit, presenting a one-entry queue, raising the request and sweeping all eight class codes with done both low and high. Before each case it rewrites the enable bit, so every take starts from the same state. The bench also checks that the external flush drops after one cycle while the request is still held, and that a head fault overrides a pending request.

// File: rtl/eir_pkg.sv
package eir_pkg;

    localparam int PC_W  = 32;
    localparam int OFF_W = 12;

    localparam logic [OFF_W-1:0] EXT_OFF    = 12'h500;
    localparam logic [OFF_W-1:0] DFAULT_OFF = 12'h300;
    localparam logic [OFF_W-1:0] IFAULT_OFF = 12'h400;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_EXT  = 2'd1,
        CAUSE_SYNC = 2'd2
    } cause_e;

    typedef enum logic [2:0] {
        CLS_ALU    = 3'd0,
        CLS_SPR_WR = 3'd1,
        CLS_ST_WR  = 3'd2,
        CLS_RETINT = 3'd3,
        CLS_MEM    = 3'd4,
        CLS_CACHE  = 3'd5,
        CLS_BRANCH = 3'd6,
        CLS_OTHER  = 3'd7
    } iclass_e;

    typedef struct packed {
        cause_e             cause;
        logic               retire;
        logic [PC_W-1:0]    resume;
        logic [OFF_W-1:0]   off;
    } decision_t;

    function automatic logic may_retire_early(input logic [2:0] cls);
        case (iclass_e'(cls))
            CLS_SPR_WR, CLS_ST_WR, CLS_RETINT, CLS_MEM, CLS_CACHE: return 1'b1;
            default:                                              return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/eir_pend.sv
module eir_pend (
    input  logic irq,
    input  logic ee,
    output logic pend,
    output logic stall
);
    always_comb begin
        pend  = irq & ee;
        stall = pend;
    end
endmodule

// File: rtl/eir_decide.sv
module eir_decide
    import eir_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic              pend,
    input  logic [PC_W-1:0]   nxt_pc,
    input  logic [CNT_W-1:0]  q_count,
    input  logic              hd_done,
    input  logic              hd_exc,
    input  logic [2:0]        hd_cls,
    input  logic [PC_W-1:0]   hd_pc,
    input  logic [OFF_W-1:0]  hd_vec_off,
    output decision_t         dec
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic present;
    logic head_fault;

    always_comb begin
        present    = (q_count != '0);
        head_fault = present & hd_done & hd_exc;
        dec        = '{cause: CAUSE_NONE, retire: 1'b0, resume: hd_pc, off: EXT_OFF};

        if (head_fault) begin
            dec.cause  = CAUSE_SYNC;
            dec.resume = hd_pc;
            dec.off    = hd_vec_off;
        end else if (pend) begin
            if (!present) begin
                dec.cause  = CAUSE_EXT;
                dec.resume = nxt_pc;
            end else if (q_count > ONE) begin
                dec.retire = hd_done;
            end else if (hd_done && may_retire_early(hd_cls)) begin
                dec.retire = 1'b1;
                dec.cause  = CAUSE_EXT;
                dec.resume = hd_pc + PC_W'(4);
            end else begin
                dec.cause  = CAUSE_EXT;
                dec.resume = hd_pc;
            end
        end else begin
            dec.retire = present & hd_done;
        end
    end
endmodule

// File: rtl/eir_state.sv
module eir_state
    import eir_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [PC_W-1:0]  resume,
    input  logic             rfi_strobe,
    input  logic             ee_wr,
    input  logic             ee_wdata,
    output logic             ee_q,
    output logic             saved_ee_q,
    output logic [PC_W-1:0]  srr0_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ee_q       <= 1'b0;
            saved_ee_q <= 1'b0;
            srr0_q     <= '0;
        end else if (take) begin
            ee_q       <= 1'b0;
            saved_ee_q <= ee_q;
            srr0_q     <= resume;
        end else if (rfi_strobe) begin
            ee_q       <= saved_ee_q;
        end else if (ee_wr) begin
            ee_q       <= ee_wdata;
        end
    end
endmodule

// File: rtl/ext_irq_recog.sv
module ext_irq_recog
    import eir_pkg::*;
#(
    parameter int               DEPTH    = 4,
    parameter logic [31:0]      VEC_BASE = 32'hFFF0_0000,
    localparam int              CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_irq,
    input  logic [31:0]       nxt_pc,
    input  logic [CNT_W-1:0]  q_count,
    input  logic              hd_done,
    input  logic              hd_exc,
    input  logic [2:0]        hd_cls,
    input  logic [31:0]       hd_pc,
    input  logic [11:0]       hd_vec_off,
    input  logic              rfi_strobe,
    input  logic              ee_wr,
    input  logic              ee_wdata,
    output logic              retire,
    output logic              disp_stall,
    output logic              flush,
    output logic [1:0]        take_cause,
    output logic [31:0]       redirect_pc,
    output logic [31:0]       srr0_pc,
    output logic              msr_ee,
    output logic              saved_ee
);
    logic      pend;
    logic      take;
    decision_t dec;

    eir_pend pend_i (
        .irq   (ext_irq),
        .ee    (msr_ee),
        .pend  (pend),
        .stall (disp_stall)
    );

    eir_decide #(.CNT_W(CNT_W)) dec_i (
        .pend       (pend),
        .nxt_pc     (nxt_pc),
        .q_count    (q_count),
        .hd_done    (hd_done),
        .hd_exc     (hd_exc),
        .hd_cls     (hd_cls),
        .hd_pc      (hd_pc),
        .hd_vec_off (hd_vec_off),
        .dec        (dec)
    );

    always_comb begin
        take        = (dec.cause != CAUSE_NONE);
        flush       = take;
        retire      = dec.retire;
        take_cause  = dec.cause;
        redirect_pc = VEC_BASE | {{(PC_W-OFF_W){1'b0}}, dec.off};
    end

    eir_state state_i (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .resume     (dec.resume),
        .rfi_strobe (rfi_strobe),
        .ee_wr      (ee_wr),
        .ee_wdata   (ee_wdata),
        .ee_q       (msr_ee),
        .saved_ee_q (saved_ee),
        .srr0_q     (srr0_pc)
    );
endmodule

// File: rtl/ext_irq_recog_chk.sv
module ext_irq_recog_chk #(
    parameter int          CNT_W    = 3,
    parameter logic [31:0] VEC_BASE = 32'hFFF0_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              ext_irq,
    input logic [CNT_W-1:0]  q_count,
    input logic              hd_done,
    input logic              hd_exc,
    input logic              rfi_strobe,
    input logic              retire,
    input logic              disp_stall,
    input logic              flush,
    input logic [1:0]        take_cause,
    input logic [31:0]       redirect_pc,
    input logic              msr_ee,
    input logic              saved_ee
);
    assert_stall_pend_R2: assert property (@(posedge clk) disable iff (rst)
        (ext_irq && msr_ee) |-> disp_stall);

    assert_ext_needs_ee_R2: assert property (@(posedge clk) disable iff (rst)
        (take_cause == 2'd1) |-> msr_ee);

    assert_fault_no_retire_R7: assert property (@(posedge clk) disable iff (rst)
        ((q_count != '0) && hd_done && hd_exc) |-> (!retire && take_cause == 2'd2));

    assert_no_storage_vec_R8: assert property (@(posedge clk) disable iff (rst)
        (take_cause == 2'd1) |-> (redirect_pc[11:0] != 12'h300 && redirect_pc[11:0] != 12'h400));

    assert_take_clears_ee_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !msr_ee);

    assert_ext_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        (take_cause == 2'd1) |=> (take_cause != 2'd1));

    assert_rfi_restore_R10: assert property (@(posedge clk) disable iff (rst)
        (rfi_strobe && !flush) |=> (msr_ee == $past(saved_ee)));
endmodule

bind ext_irq_recog ext_irq_recog_chk #(.CNT_W(CNT_W), .VEC_BASE(VEC_BASE)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ext_irq     (ext_irq),
    .q_count     (q_count),
    .hd_done     (hd_done),
    .hd_exc      (hd_exc),
    .rfi_strobe  (rfi_strobe),
    .retire      (retire),
    .disp_stall  (disp_stall),
    .flush       (flush),
    .take_cause  (take_cause),
    .redirect_pc (redirect_pc),
    .msr_ee      (msr_ee),
    .saved_ee    (saved_ee)
);

// File: tb/ext_irq_recog_tb_top.sv
module ext_irq_recog_tb_top;
    localparam logic [31:0] BASE = 32'hFFF0_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_irq = 1'b0;
    logic [31:0] nxt_pc = 32'h0;
    logic [2:0]  q_count = 3'd0;
    logic        hd_done = 1'b0;
    logic        hd_exc = 1'b0;
    logic [2:0]  hd_cls = 3'd0;
    logic [31:0] hd_pc = 32'h0;
    logic [11:0] hd_vec_off = 12'h0;
    logic        rfi_strobe = 1'b0;
    logic        ee_wr = 1'b0;
    logic        ee_wdata = 1'b0;
    logic        retire, disp_stall, flush, msr_ee, saved_ee;
    logic [1:0]  take_cause;
    logic [31:0] redirect_pc, srr0_pc;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    ext_irq_recog dut_i (
        .clk(clk), .rst(rst), .ext_irq(ext_irq), .nxt_pc(nxt_pc),
        .q_count(q_count), .hd_done(hd_done), .hd_exc(hd_exc), .hd_cls(hd_cls),
        .hd_pc(hd_pc), .hd_vec_off(hd_vec_off), .rfi_strobe(rfi_strobe),
        .ee_wr(ee_wr), .ee_wdata(ee_wdata), .retire(retire),
        .disp_stall(disp_stall), .flush(flush), .take_cause(take_cause),
        .redirect_pc(redirect_pc), .srr0_pc(srr0_pc), .msr_ee(msr_ee),
        .saved_ee(saved_ee)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit early_ok(input logic [2:0] c);
        return (c >= 3'd1) && (c <= 3'd5);
    endfunction

    task automatic set_ee(input logic v);
        @(negedge clk);
        ext_irq = 1'b0; q_count = 3'd0; ee_wr = 1'b1; ee_wdata = v;
        @(negedge clk);
        ee_wr = 1'b0;
    endtask

    task automatic head(input logic [2:0] cnt, input logic dn, input logic ex,
                        input logic [2:0] cls, input logic [31:0] pc);
        q_count = cnt; hd_done = dn; hd_exc = ex; hd_cls = cls; hd_pc = pc;
    endtask

    initial begin
        #(8 * 200000);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "msr_ee", msr_ee, 0);
        check("R1", "saved_ee", saved_ee, 0);
        check("R1", "srr0", srr0_pc, 0);
        check("R1", "flush", flush, 0);
        check("R1", "stall", disp_stall, 0);
        @(negedge clk); rst = 1'b0;

        // R11: normal retirement, no request
        set_ee(1'b1);
        for (int c = 0; c <= 4; c++) begin
            for (int d = 0; d < 2; d++) begin
                @(negedge clk);
                head(3'(c), 1'(d), 1'b0, 3'd0, 32'h100);
                #1;
                check("R11", "retire", retire, 32'((c != 0) && (d == 1)));
                check("R11", "flush", flush, 0);
            end
        end

        // R2: request masked while enable is clear
        set_ee(1'b0);
        @(negedge clk);
        ext_irq = 1'b1; head(3'd1, 1'b0, 1'b0, 3'd0, 32'h200);
        #1;
        check("R2", "flush masked", flush, 0);
        check("R2", "stall masked", disp_stall, 0);
        @(negedge clk); ext_irq = 1'b0;

        // R3: older entries retire while pending
        set_ee(1'b1);
        for (int c = 2; c <= 4; c++) begin
            for (int d = 0; d < 2; d++) begin
                @(negedge clk);
                ext_irq = 1'b1; head(3'(c), 1'(d), 1'b0, 3'd7, 32'h300);
                #1;
                check("R3", "retire older", retire, 32'(d));
                check("R3", "no flush", flush, 0);
                check("R2", "stall pending", disp_stall, 1);
            end
        end
        @(negedge clk); ext_irq = 1'b0;

        // R4/R5: sweep of the youngest entry
        for (int cl = 0; cl < 8; cl++) begin
            for (int d = 0; d < 2; d++) begin
                logic [31:0] pc;
                bit ok;
                pc = 32'h1000 + 32'(cl * 64 + d * 16);
                ok = (d == 1) && early_ok(3'(cl));
                set_ee(1'b1);
                @(negedge clk);
                ext_irq = 1'b1; head(3'd1, 1'(d), 1'b0, 3'(cl), pc);
                #1;
                check(ok ? "R4" : "R5", "retire youngest", retire, 32'(ok));
                check("R8", "cause ext", take_cause, 1);
                check("R8", "vector", redirect_pc, BASE | 32'h500);
                @(posedge clk); #1;
                check(ok ? "R4" : "R5", "resume", srr0_pc, ok ? pc + 4 : pc);
                check("R9", "ee cleared", msr_ee, 0);
                check("R9", "saved ee", saved_ee, 1);
                check("R9", "one-cycle flush", flush, 0);
                @(negedge clk); ext_irq = 1'b0;
            end
        end

        // R6: empty queue
        set_ee(1'b1);
        @(negedge clk);
        ext_irq = 1'b1; nxt_pc = 32'h0000_ABC0; head(3'd0, 1'b0, 1'b0, 3'd0, 32'h0);
        #1;
        check("R6", "flush empty", flush, 1);
        check("R6", "retire empty", retire, 0);
        @(posedge clk); #1;
        check("R6", "resume nxt", srr0_pc, 32'h0000_ABC0);
        @(negedge clk); ext_irq = 1'b0;

        // R7: head fault beats pending request; also with enable clear
        for (int e = 0; e < 2; e++) begin
            set_ee(1'(e));
            @(negedge clk);
            ext_irq = 1'b1; hd_vec_off = 12'h700;
            head(3'd3, 1'b1, 1'b1, 3'd4, 32'h5550);
            #1;
            check("R7", "fault cause", take_cause, 2);
            check("R7", "fault no retire", retire, 0);
            check("R7", "fault vector", redirect_pc, BASE | 32'h700);
            @(posedge clk); #1;
            check("R7", "fault resume", srr0_pc, 32'h5550);
            check("R9", "fault saved ee", saved_ee, 32'(e));
            check("R9", "fault ee cleared", msr_ee, 0);
            @(negedge clk); ext_irq = 1'b0; q_count = 3'd0;
        end

        // R10: rfi restores, ee_wr writes, take wins over rfi
        set_ee(1'b1);
        @(negedge clk);
        ext_irq = 1'b1; head(3'd0, 1'b0, 1'b0, 3'd0, 32'h0);
        @(negedge clk);
        ext_irq = 1'b0; rfi_strobe = 1'b1; ee_wr = 1'b1; ee_wdata = 1'b0;
        @(posedge clk); #1;
        check("R10", "rfi over ee_wr", msr_ee, 1);
        @(negedge clk);
        rfi_strobe = 1'b0; ee_wr = 1'b1; ee_wdata = 1'b0;
        @(posedge clk); #1;
        check("R10", "ee_wr clear", msr_ee, 0);
        @(negedge clk); ee_wr = 1'b0;
        set_ee(1'b1);
        @(negedge clk);
        ext_irq = 1'b1; rfi_strobe = 1'b1; q_count = 3'd0;
        @(posedge clk); #1;
        check("R10", "take over rfi", msr_ee, 0);
        @(negedge clk); ext_irq = 1'b0; rfi_strobe = 1'b0;

        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule